// File: doc/BRIEF.md
# Hit halo filter

The block sits after a correlated double sampler in a pixel-sensor readout path. It takes the raster-ordered stream of per-pixel frame differences, each carrying a hit flag, and passes on only the pixels inside the 3x3 neighbourhood of any hit pixel. Every other pixel of the matrix is dropped, so far fewer words go downstream than in a full-frame readout.

The block keeps two earlier rows of hit flags and values in line memories, plus a two-column register window. A pixel can be judged once the pixel below and to its right has been seen. The decisions run one row and one column behind the input. When a window covers a pixel more than once, that pixel still goes out once. Once the last pixel of a frame is accepted, the block feeds itself one extra row of empty pixels to judge the rows still pending. It then emits a trailer word that carries the frame number and the number of pixel words sent.

Top module: `hit_halo_filter`

## Requirements
- R1: After reset, out_valid is low, and the first trailer emitted carries frame number 0.
- R2: A pixel (r,c) of a frame is emitted if and only if some pixel (r',c') of the same frame with in_hit=1 satisfies |r-r'|<=1 and |c-c'|<=1.
- R3: Neighbourhoods are cut at the matrix border. A hit in the last column does not select pixels in column 0 of any row, and a hit in the last row does not select anything in row 0.
- R4: Within a frame, each selected pixel is emitted exactly once, and the words come in strictly increasing row-major order (row first, then column).
- R5: A pixel word has out_trailer=0 and carries the pixel's row on out_row, its column on out_col, and the signed difference that was received for that pixel on out_diff.
- R6: After the last pixel word of a frame, one trailer word is emitted with out_trailer=1. Its out_count equals the number of pixel words emitted for that frame.
- R7: The out_frame value of each trailer is one more than that of the previous trailer, modulo 2^FW.
- R8: Idle cycles (in_valid=0) between pixels of a frame do not change which words are emitted or what they contain.
- R9: The trailer is present on the outputs exactly NCOL+3 clock cycles after the clock edge that accepts the pixel with in_eof=1. The next frame's first pixel may be given no earlier than that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_row | input | $clog2(NROW) | Row of the input pixel |
| in_col | input | $clog2(NCOL) | Column of the input pixel |
| in_diff | input | DW | Signed frame difference of the pixel |
| in_hit | input | 1 | Pixel is above threshold |
| in_eof | input | 1 | Last pixel of the frame |
| out_valid | output | 1 | Output word present this cycle |
| out_trailer | output | 1 | 1 for a trailer word, 0 for a pixel word |
| out_row | output | $clog2(NROW) | Row of the emitted pixel |
| out_col | output | $clog2(NCOL) | Column of the emitted pixel |
| out_diff | output | DW | Difference of the emitted pixel |
| out_frame | output | FW | Frame number (trailer words) |
| out_count | output | $clog2(NROW*NCOL+1) | Pixel words in the frame (trailer words) |

## Verification
A corrupted line memory or column window shows at the ports as missing or extra neighbours, or as a wrong difference value. Either one is caught at the very next word of that frame, or at the trailer's count when the set is too small. A fault in the wrap handling at column 0 selects a pixel from the opposite border, which the single-hit sweep over every position exposes. A fault in the flush sequencer shows up as missing last-row words, or as a trailer that arrives at the wrong cycle, and this is detected within NCOL+3 cycles of the end of frame.

// File: rtl/halo_pkg.sv
package halo_pkg;
  // Hit flags of one column of the 3-row window, oldest row on top.
  typedef struct packed {
    logic top;
    logic mid;
    logic bot;
  } hcol_t;

  // Token travelling through the pipeline.
  typedef enum logic {TOK_PIX = 1'b0, TOK_TRL = 1'b1} tok_e;
endpackage

// File: rtl/halo_linebuf.sv
// Single-port-per-direction line memory with registered read, block RAM friendly.
module halo_linebuf #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 14,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/halo_window.sv
// Two-column hit window; with the incoming column it forms the 3x3 neighbourhood
// of the pixel held in the newer window column.
module halo_window import halo_pkg::*; #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,       // a pixel token is shifted in
  input  logic          col_zero,  // incoming column is column 0 (new row)
  input  logic          top_mask,  // top row of the window lies above the matrix
  input  hcol_t         ncol,
  input  logic [DW-1:0] nval,
  output logic          sel,
  output logic [DW-1:0] ctr_val
);
  hcol_t         w_lft, w_ctr, rgt;
  logic [DW-1:0] v_ctr;
  logic [2:0]    tops;

  always_comb begin
    rgt     = col_zero ? '0 : ncol;   // no wrap from column 0 back to the last column
    tops    = {w_lft.top, w_ctr.top, rgt.top} & {3{~top_mask}};
    sel     = (|tops) | w_lft.mid | w_lft.bot | w_ctr.mid | w_ctr.bot | rgt.mid | rgt.bot;
    ctr_val = v_ctr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_lft <= '0;
      w_ctr <= '0;
      v_ctr <= '0;
    end else if (adv) begin
      w_lft <= col_zero ? '0 : w_ctr;  // column -1 is empty
      w_ctr <= ncol;
      v_ctr <= nval;
    end
  end
endmodule

// File: rtl/hit_halo_filter.sv
module hit_halo_filter import halo_pkg::*; #(
  parameter int NROW = 256,
  parameter int NCOL = 256,
  parameter int DW   = 12,
  parameter int FW   = 8,
  localparam int RW  = $clog2(NROW),
  localparam int CW  = $clog2(NCOL),
  localparam int NW  = $clog2(NROW*NCOL+1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [RW-1:0]        in_row,
  input  logic [CW-1:0]        in_col,
  input  logic signed [DW-1:0] in_diff,
  input  logic                 in_hit,
  input  logic                 in_eof,
  output logic                 out_valid,
  output logic                 out_trailer,
  output logic [RW-1:0]        out_row,
  output logic [CW-1:0]        out_col,
  output logic signed [DW-1:0] out_diff,
  output logic [FW-1:0]        out_frame,
  output logic [NW-1:0]        out_count
);
  localparam int AW = RW + 2;            // arrival row, includes virtual flush rows
  localparam int KW = $clog2(NCOL + 2);  // flush step counter
  localparam int MW = DW + 2;            // line word: {hit r-1, value r-1, hit r-2}

  // ---------------- source select: live input or flush tokens ----------------
  logic          fl_on;
  logic [KW-1:0] fl_k;
  logic          src_go, src_hit;
  tok_e          src_tok;
  logic [AW-1:0] src_row;
  logic [CW-1:0] src_col;
  logic [DW-1:0] src_val;

  always_comb begin
    src_go  = in_valid | fl_on;
    src_tok = TOK_PIX;
    src_row = AW'(in_row);
    src_col = in_col;
    src_hit = in_hit;
    src_val = in_diff;
    if (fl_on) begin
      src_hit = 1'b0;
      src_val = '0;
      if (fl_k < KW'(NCOL)) begin
        src_row = AW'(NROW);
        src_col = CW'(fl_k);
      end else if (fl_k == KW'(NCOL)) begin
        src_row = AW'(NROW + 1);
        src_col = '0;
      end else begin
        src_tok = TOK_TRL;
        src_row = '0;
        src_col = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_on <= 1'b0;
      fl_k  <= '0;
    end else if (!fl_on) begin
      if (in_valid && in_eof) begin
        fl_on <= 1'b1;
        fl_k  <= '0;
      end
    end else if (fl_k == KW'(NCOL + 1)) begin
      fl_on <= 1'b0;
    end else begin
      fl_k <= fl_k + 1'b1;
    end
  end

  // ---------------- stage 0: token register and line memory read ----------------
  logic          s_vld, s_hit;
  tok_e          s_tok;
  logic [AW-1:0] s_row;
  logic [CW-1:0] s_col;
  logic [DW-1:0] s_val;
  logic [MW-1:0] rd_word;
  logic          s_pix;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_vld <= 1'b0;
      s_tok <= TOK_PIX;
      s_row <= '0;
      s_col <= '0;
      s_hit <= 1'b0;
      s_val <= '0;
    end else begin
      s_vld <= src_go;
      s_tok <= src_tok;
      s_row <= src_row;
      s_col <= src_col;
      s_hit <= src_hit;
      s_val <= src_val;
    end
  end

  assign s_pix = s_vld && (s_tok == TOK_PIX);

  halo_linebuf #(.DEPTH(NCOL), .WIDTH(MW)) u_lines (
    .clk     (clk),
    .rd_en   (src_go && (src_tok == TOK_PIX)),
    .rd_addr (src_col),
    .rd_data (rd_word),
    .wr_en   (s_pix),
    .wr_addr (s_col),
    .wr_data ({s_hit, s_val, rd_word[MW-1]})
  );

  // ---------------- stage 1: window decision ----------------
  hcol_t         ncol;
  logic          col_zero, top_mask, ctr_ok, sel, emit, trl;
  logic [DW-1:0] ctr_val;
  logic [RW-1:0] dec_row;
  logic [CW-1:0] dec_col;

  always_comb begin
    ncol     = '{top: rd_word[0], mid: rd_word[MW-1], bot: s_hit};
    col_zero = (s_col == '0);
    // Column 0 closes the last column two rows up; other columns close (row-1, col-1).
    ctr_ok   = col_zero ? (s_row >= AW'(2)) : (s_row >= AW'(1));
    top_mask = col_zero ? (s_row == AW'(2)) : (s_row == AW'(1));
    dec_row  = col_zero ? RW'(s_row - AW'(2)) : RW'(s_row - AW'(1));
    dec_col  = col_zero ? CW'(NCOL - 1) : (s_col - 1'b1);
    emit     = s_pix && ctr_ok && sel;
    trl      = s_vld && (s_tok == TOK_TRL);
  end

  halo_window #(.DW(DW)) u_win (
    .clk      (clk),
    .rst      (rst),
    .adv      (s_pix),
    .col_zero (col_zero),
    .top_mask (top_mask),
    .ncol     (ncol),
    .nval     (rd_word[MW-2:1]),
    .sel      (sel),
    .ctr_val  (ctr_val)
  );

  // ---------------- output register ----------------
  logic [NW-1:0] cnt_q;
  logic [FW-1:0] frm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_trailer <= 1'b0;
      out_row     <= '0;
      out_col     <= '0;
      out_diff    <= '0;
      out_frame   <= '0;
      out_count   <= '0;
      cnt_q       <= '0;
      frm_q       <= '0;
    end else begin
      out_valid   <= emit | trl;
      out_trailer <= trl;
      if (emit) begin
        out_row  <= dec_row;
        out_col  <= dec_col;
        out_diff <= ctr_val;
        cnt_q    <= cnt_q + 1'b1;
      end
      if (trl) begin
        out_frame <= frm_q;
        out_count <= cnt_q;
        cnt_q     <= '0;
        frm_q     <= frm_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hit_halo_filter_chk.sv
module hit_halo_filter_chk #(
  parameter int NROW = 256,
  parameter int NCOL = 256,
  parameter int DW   = 12,
  parameter int FW   = 8,
  localparam int RW  = $clog2(NROW),
  localparam int CW  = $clog2(NCOL),
  localparam int NW  = $clog2(NROW*NCOL+1)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_eof,
  input logic          out_valid,
  input logic          out_trailer,
  input logic [RW-1:0] out_row,
  input logic [CW-1:0] out_col,
  input logic [FW-1:0] out_frame,
  input logic [NW-1:0] out_count
);
  logic                rst_d, have_last, have_trl, eof_pend;
  logic [RW+CW-1:0]    last_pos;
  logic [NW-1:0]       seen_cnt;
  logic [FW-1:0]       last_frame;
  logic                pix_w, trl_w;

  assign pix_w = out_valid && !out_trailer;
  assign trl_w = out_valid && out_trailer;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      have_last <= 1'b0;
      have_trl  <= 1'b0;
      eof_pend  <= 1'b0;
      last_pos  <= '0;
      seen_cnt  <= '0;
      last_frame <= '0;
    end else begin
      if (in_valid && in_eof) eof_pend <= 1'b1;
      if (pix_w) begin
        have_last <= 1'b1;
        last_pos  <= {out_row, out_col};
        seen_cnt  <= seen_cnt + 1'b1;
      end
      if (trl_w) begin
        have_last  <= 1'b0;
        seen_cnt   <= '0;
        have_trl   <= 1'b1;
        last_frame <= out_frame;
        eof_pend   <= 1'b0;
      end
    end
  end

  // R1: quiet output in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> !out_valid);
  // R3: coordinates stay inside the matrix
  a_r3_inside_matrix: assert property (@(posedge clk) disable iff (rst)
    pix_w |-> (out_row < RW'(NROW - 1) || out_row == RW'(NROW - 1)) &&
              (out_col < CW'(NCOL - 1) || out_col == CW'(NCOL - 1)));
  // R4: strictly increasing raster order within a frame
  a_r4_raster_order: assert property (@(posedge clk) disable iff (rst)
    pix_w && have_last |-> {out_row, out_col} > last_pos);
  // R6: trailer count matches the pixel words seen
  a_r6_trailer_count: assert property (@(posedge clk) disable iff (rst)
    trl_w |-> out_count == seen_cnt);
  // R7: frame number steps by one
  a_r7_frame_step: assert property (@(posedge clk) disable iff (rst)
    trl_w && have_trl |-> out_frame == last_frame + 1'b1);
  // R9: a trailer only follows an accepted end-of-frame pixel
  a_r9_trailer_after_eof: assert property (@(posedge clk) disable iff (rst)
    trl_w |-> eof_pend);
endmodule

bind hit_halo_filter hit_halo_filter_chk #(.NROW(NROW), .NCOL(NCOL), .DW(DW), .FW(FW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_eof      (in_eof),
  .out_valid   (out_valid),
  .out_trailer (out_trailer),
  .out_row     (out_row),
  .out_col     (out_col),
  .out_frame   (out_frame),
  .out_count   (out_count)
);

// File: tb/tb_hit_halo_filter.sv
module tb_hit_halo_filter;
  localparam int NR = 6;
  localparam int NC = 5;
  localparam int DW = 8;
  localparam int FW = 3;
  localparam int RW = $clog2(NR);
  localparam int CW = $clog2(NC);
  localparam int NW = $clog2(NR*NC+1);
  localparam int NP = NR*NC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_hit = 1'b0, in_eof = 1'b0;
  logic [RW-1:0] in_row = '0;
  logic [CW-1:0] in_col = '0;
  logic signed [DW-1:0] in_diff = '0;
  logic out_valid, out_trailer;
  logic [RW-1:0] out_row;
  logic [CW-1:0] out_col;
  logic signed [DW-1:0] out_diff;
  logic [FW-1:0] out_frame;
  logic [NW-1:0] out_count;

  hit_halo_filter #(.NROW(NR), .NCOL(NC), .DW(DW), .FW(FW)) dut (.*);

  always #4 clk = ~clk;

  int n_checks = 0, n_errors = 0;
  int cyc = 0;
  int eof_cyc = 0;
  int exp_n = 0;
  int exp_r [NP];
  int exp_c [NP];
  int exp_v [NP];
  int got_n = 0;
  int trl_count = 0;
  int exp_frame = 0;
  int fr_tag = 0;
  string tag = "R2";
  logic [NP-1:0] hmap;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int val_of(input int r, input int c, input int f);
    logic signed [DW-1:0] v;
    v = DW'(r*37 + c*11 + f*5 - 60);
    return int'(v);
  endfunction

  task automatic build_exp();
    exp_n = 0;
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) begin
        bit s = 0;
        for (int dr = -1; dr <= 1; dr++)
          for (int dc = -1; dc <= 1; dc++) begin
            int rr = r + dr;
            int cc = c + dc;
            if (rr >= 0 && rr < NR && cc >= 0 && cc < NC && hmap[rr*NC+cc]) s = 1;
          end
        if (s) begin
          exp_r[exp_n] = r;
          exp_c[exp_n] = c;
          exp_v[exp_n] = val_of(r, c, fr_tag);
          exp_n++;
        end
      end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 60000);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  // Output monitor: sampled away from the active edge.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (!out_trailer) begin
        if (got_n >= exp_n) begin
          chk(0, {tag, " extra word"}, int'(out_row)*100 + int'(out_col), -1);
        end else begin
          chk(out_row == RW'(exp_r[got_n]) && out_col == CW'(exp_c[got_n]), {tag, " R4 position"},
              int'(out_row)*100 + int'(out_col), exp_r[got_n]*100 + exp_c[got_n]);
          chk(int'(out_diff) == exp_v[got_n], "R5 value", int'(out_diff), exp_v[got_n]);
        end
        got_n++;
      end else begin
        chk(int'(out_count) == exp_n, "R6 count", int'(out_count), exp_n);
        chk(got_n == exp_n, {tag, " words seen"}, got_n, exp_n);
        chk(int'(out_frame) == (exp_frame % (1 << FW)), "R7 frame", int'(out_frame), exp_frame % (1 << FW));
        chk(cyc - eof_cyc == NC + 3, "R9 trailer latency", cyc - eof_cyc, NC + 3);
        exp_frame++;
        got_n = 0;
        trl_count++;
      end
    end
  end

  task automatic send_frame(input bit gaps);
    int target;
    target = trl_count + 1;
    build_exp();
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) begin
        if (gaps && ((r*NC + c) % 3 == 1)) begin
          @(negedge clk);
          in_valid = 1'b0;
          @(negedge clk);
        end else begin
          @(negedge clk);
        end
        in_valid = 1'b1;
        in_row   = RW'(r);
        in_col   = CW'(c);
        in_hit   = hmap[r*NC + c];
        in_diff  = DW'(val_of(r, c, fr_tag));
        in_eof   = (r == NR-1) && (c == NC-1);
        if (in_eof) eof_cyc = cyc + 1;
      end
    @(negedge clk);
    in_valid = 1'b0;
    in_eof   = 1'b0;
    while (trl_count < target) @(negedge clk);
    @(negedge clk);
    fr_tag++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 idle after reset", int'(out_valid), 0);

    // R1 first frame (frame 0, empty) and R2 no hit -> only trailer
    tag = "R1"; hmap = '0; send_frame(0);
    // R4: all hits, every pixel once
    tag = "R4"; hmap = '1; send_frame(0);
    // R3: single hit at every position, borders included
    tag = "R3";
    for (int p = 0; p < NP; p++) begin
      hmap = '0;
      hmap[p] = 1'b1;
      send_frame(0);
    end
    // R3: all four corners together
    hmap = '0;
    hmap[0] = 1'b1; hmap[NC-1] = 1'b1; hmap[(NR-1)*NC] = 1'b1; hmap[NP-1] = 1'b1;
    send_frame(0);
    // R3: hit at end of a row next to the start of the following row
    hmap = '0; hmap[2*NC-1] = 1'b1; hmap[2*NC] = 1'b1; send_frame(0);
    // R4: adjacent hits with overlapping windows
    tag = "R4";
    hmap = '0; hmap[2*NC+1] = 1'b1; hmap[2*NC+2] = 1'b1; hmap[3*NC+2] = 1'b1; send_frame(0);
    // R2: random patterns
    tag = "R2";
    for (int f = 0; f < 12; f++) begin
      for (int p = 0; p < NP; p++) hmap[p] = ($urandom_range(0, 7) == 0);
      send_frame(0);
    end
    // R8: same kind of patterns with idle cycles inside the frame
    tag = "R8";
    for (int f = 0; f < 6; f++) begin
      for (int p = 0; p < NP; p++) hmap[p] = ($urandom_range(0, 5) == 0);
      send_frame(1);
    end

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule